// File: doc/BRIEF.md
# GPIO Bank Register Block

This block is one 32-pin general-purpose I/O bank that sits behind a plain 32-bit register bus. Software sets each pin's direction and writes an output latch. Single pins can change through two write-one ports, one that sets bits and one that clears them, so no read-modify-write sequence is needed. Software reads the pin levels through an input register whose value has been synchronized, and a fixed identification word tells drivers which revision they are talking to.

The pad side has three vectors. The output-value vector carries the latch. The output-enable vector goes to external tri-state buffers. The raw input vector comes back from the pads. The direction register is stored in input sense, where a 1 means the driver is off. The block inverts it to produce the active-high enable that the pads expect.

Register offsets are fixed because software decodes them. Revision is at 0x000, direction at 0x134, input data at 0x138, output latch at 0x13C, latch clear at 0x190 and latch set at 0x194. Pin n is bit n of every per-pin register.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF, so every pin is an input. The output latch is zero, pin_oe_o is all zeros and rvalid_o is low.
- R2: A write to offset 0x134 replaces the direction register. A bit value of 1 makes that pin an input and 0 makes it an output. From the cycle after the write, pin_oe_o is the bitwise inverse of the direction register.
- R3: A write to offset 0x13C replaces the whole output latch, and reads of 0x13C return it. pin_out_o shows the new value from the cycle after the write.
- R4: A write to offset 0x194 sets every latch bit where the written bit is 1. All other latch bits keep their value.
- R5: A write to offset 0x190 clears every latch bit where the written bit is 1. All other latch bits keep their value.
- R6: Offset 0x138 reads the pin levels after a two-flop synchronizer. A level applied to pin_in_i before clock edge k appears in this register after edge k+1. A read issued one cycle after the change therefore still returns the old level.
- R7: Offset 0x000 always reads 0x50600801.
- R8: Reads of 0x190, 0x194 and any unmapped offset return zero. Writes to 0x000, 0x138 and unmapped offsets change neither the latch nor the direction.
- R9: A read strobe at clock edge k yields rvalid_o high with the data for the cycle after edge k. rvalid_o is low in every cycle that does not follow a read strobe.
- R10: rdata_o is zero whenever rvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register being accessed |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| pin_in_i | input | 32 | Raw pin levels from the pads |
| pin_out_o | output | 32 | Output latch driven to the pads |
| pin_oe_o | output | 32 | Active-high pad output enable |

## Verification
The assertions check the following on every cycle:
- whole-word writes to direction and latch, seen at pin_oe_o and pin_out_o;
- the set and clear arithmetic on the latch;
- the one-cycle read-valid timing and zero data when no read is valid;
- the revision word, and zeros read back from the set and clear ports;
- pad outputs that stay unchanged across writes to read-only offsets.

Some behaviours only the directed scenarios can show: the reset contents, the exact two-edge synchronizer delay on input data, and bits that stay untouched across mixed set, clear and full-word sequences.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_REV  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 12'h138;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 12'h13C;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_SET  = 12'h194;

  localparam logic [DATA_W-1:0] REV_ID = 32'h5060_0801;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REV,
    SEL_DIR,
    SEL_DIN,
    SEL_DOUT,
    SEL_CLR,
    SEL_SET
  } reg_sel_e;

  typedef struct packed {
    logic wr_dir;
    logic wr_dout;
    logic wr_set;
    logic wr_clr;
  } wr_ctl_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output reg_sel_e          sel_o,
  output wr_ctl_t           wctl_o
);
  always_comb begin
    unique case (addr_i)
      OFS_REV:  sel_o = SEL_REV;
      OFS_DIR:  sel_o = SEL_DIR;
      OFS_DIN:  sel_o = SEL_DIN;
      OFS_DOUT: sel_o = SEL_DOUT;
      OFS_CLR:  sel_o = SEL_CLR;
      OFS_SET:  sel_o = SEL_SET;
      default:  sel_o = SEL_NONE;
    endcase
  end

  // only writable targets produce strobes; RO and unmapped drop the write
  always_comb begin
    wctl_o         = '0;
    wctl_o.wr_dir  = wr_i && (sel_o == SEL_DIR);
    wctl_o.wr_dout = wr_i && (sel_o == SEL_DOUT);
    wctl_o.wr_set  = wr_i && (sel_o == SEL_SET);
    wctl_o.wr_clr  = wr_i && (sel_o == SEL_CLR);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_ctl_t             wctl_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            dir_o <= '1;
    else if (wctl_i.wr_dir) dir_o <= wdata_i;
  end

  // per-bit update; set and clear touch only their one-bits
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             dout_o[p] <= 1'b0;
      else if (wctl_i.wr_dout)                 dout_o[p] <= wdata_i[p];
      else if (wctl_i.wr_set && wdata_i[p])    dout_o[p] <= 1'b1;
      else if (wctl_i.wr_clr && wdata_i[p])    dout_o[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic [NUM_PINS-1:0] din_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    unique case (sel_i)
      SEL_REV:  mux_d = REV_ID;
      SEL_DIR:  mux_d[NUM_PINS-1:0] = dir_i;
      SEL_DIN:  mux_d[NUM_PINS-1:0] = din_i;
      SEL_DOUT: mux_d[NUM_PINS-1:0] = dout_i;
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? mux_d : '0;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  reg_sel_e            sel;
  wr_ctl_t             wctl;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] dout_q;
  logic [NUM_PINS-1:0] din_q;

  gpio_addr_dec u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .sel_o  (sel),
    .wctl_o (wctl)
  );

  gpio_out_regs #(.NUM_PINS(NUM_PINS)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wctl_i  (wctl),
    .wdata_i (wdata_i[NUM_PINS-1:0]),
    .dir_o   (dir_q),
    .dout_o  (dout_q)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (din_q)
  );

  gpio_rd_port #(.NUM_PINS(NUM_PINS)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .sel_i    (sel),
    .dir_i    (dir_q),
    .dout_i   (dout_q),
    .din_i    (din_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign pin_out_o = dout_q;
  assign pin_oe_o  = ~dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                rd_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                rvalid_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  p_dir_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_DIR |=> pin_oe_o == ~$past(wdata_i[NUM_PINS-1:0]));

  p_dout_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_DOUT |=> pin_out_o == $past(wdata_i[NUM_PINS-1:0]));

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_SET |=>
      pin_out_o == ($past(pin_out_o) | $past(wdata_i[NUM_PINS-1:0])));

  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_CLR |=>
      pin_out_o == ($past(pin_out_o) & ~$past(wdata_i[NUM_PINS-1:0])));

  p_rev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFS_REV |=> rdata_o == REV_ID);

  p_port_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i == OFS_SET || addr_i == OFS_CLR) |=> rdata_o == '0);

  p_ro_wr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i == OFS_REV || addr_i == OFS_DIN) |=>
      $stable(pin_out_o) && $stable(pin_oe_o));

  p_rvalid_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  p_rvalid_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o)
);

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  import gpio_bank_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 1'b0;
  logic [31:0]       wdata = '0;
  logic              rd = 1'b0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [31:0]       pin_in = '0;
  logic [31:0]       pin_out;
  logic [31:0]       pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_bank_regs u0 (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_i (wr),
    .wdata_i (wdata), .rd_i (rd), .rdata_o (rdata), .rvalid_o (rvalid),
    .pin_in_i (pin_in), .pin_out_o (pin_out), .pin_oe_o (pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R9 rvalid after read", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 latch after reset", pin_out, 32'h0);
    chk("R1 rvalid after reset", {31'd0, rvalid}, 32'd0);
    bus_rd(OFS_DIR, v);
    chk("R1 dir reads all ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_revision();
    logic [31:0] v;
    bus_rd(OFS_REV, v);
    chk("R7 revision", v, 32'h5060_0801);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    bus_wr(OFS_DIR, 32'h0F0F_00FF);
    chk("R2 oe inverse", pin_oe, 32'hF0F0_FF00);
    bus_rd(OFS_DIR, v);
    chk("R2 dir readback", v, 32'h0F0F_00FF);
    bus_wr(OFS_DIR, 32'h0);
    chk("R2 all outputs", pin_oe, 32'hFFFF_FFFF);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    bus_wr(OFS_DOUT, 32'hA5A5_3C3C);
    chk("R3 pin_out after write", pin_out, 32'hA5A5_3C3C);
    bus_rd(OFS_DOUT, v);
    chk("R3 latch readback", v, 32'hA5A5_3C3C);
  endtask

  task automatic t_set();
    logic [31:0] v;
    bus_wr(OFS_SET, 32'h0000_0001);
    chk("R4 set bit0", pin_out, 32'hA5A5_3C3D);
    bus_wr(OFS_SET, 32'h8000_0000);
    chk("R4 set bit31 idempotent", pin_out, 32'hA5A5_3C3D);
    bus_wr(OFS_SET, 32'h0);
    chk("R4 zero set no change", pin_out, 32'hA5A5_3C3D);
    bus_rd(OFS_SET, v);
    chk("R8 set port reads zero", v, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    bus_wr(OFS_CLR, 32'hFF00_0001);
    chk("R5 clear masked", pin_out, 32'h00A5_3C3C);
    bus_wr(OFS_CLR, 32'h0);
    chk("R5 zero clear no change", pin_out, 32'h00A5_3C3C);
    bus_rd(OFS_CLR, v);
    chk("R8 clear port reads zero", v, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    bus_rd(OFS_DIN, v);
    chk("R6 input still old after one edge", v, 32'h0);
    bus_rd(OFS_DIN, v);
    chk("R6 input visible after sync", v, 32'hDEAD_BEEF);
    @(negedge clk);
    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_rd(OFS_DIN, v);
    chk("R6 second pattern", v, 32'h1234_5678);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_wr(OFS_REV, 32'hFFFF_FFFF);
    bus_wr(OFS_DIN, 32'hFFFF_FFFF);
    bus_wr(12'h200, 32'hFFFF_FFFF);
    chk("R8 latch untouched", pin_out, 32'h00A5_3C3C);
    chk("R8 dir untouched", pin_oe, 32'hFFFF_FFFF);
    bus_rd(12'h004, v);
    chk("R8 unmapped reads zero", v, 32'h0);
    bus_rd(OFS_REV, v);
    chk("R8 revision unchanged", v, 32'h5060_0801);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R9 rvalid low when idle", {31'd0, rvalid}, 32'd0);
    chk("R10 rdata zero when idle", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_revision();
    t_direction();
    t_latch();
    t_set();
    t_clear();
    t_input();
    t_unmapped();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule